// File: doc/BRIEF.md
# Translation Cache Selective Invalidation Unit

This block holds a small, fully associative cache of address translations. It carries out supervisor requests to invalidate selected entries. A request arrives as a single-cycle pulse. The pulse carries two flags that say whether the address and ASID operand registers are the zero register, a 64-bit virtual address, a 64-bit ASID operand, the requester's privilege mode, and the trap controls for virtual memory.

The block first checks whether the request must trap. A trapping request produces either an illegal-instruction or a virtual-instruction indication and touches no entry. A request that does not trap clears, in the same clock edge, every entry that falls within its scope. The scope is set by which operands are present, by whether the requester is a guest, and by whether the address is canonical. A non-canonical address turns an address-based request into a silent no-op.

A fill port loads entries for testing, and a combinational lookup port reports hits. Together they let the effect of each request be observed.

Top module: `tlb_inval_unit`

## Requirements
- R1: After reset, every entry is invalid, so every lookup misses, and `done_o`, `exc_illegal_o` and `exc_virtual_o` are low.
- R2: A request sampled with `req_valid_i` high at a clock edge produces `done_o` high for exactly the following cycle. The exception outputs are valid only while `done_o` is high, and at most one of them is set.
- R3: `req_priv_i[2]` is the virtualisation bit, and `req_priv_i[1:0]` encodes 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. Without virtualisation, a user or reserved code raises `exc_illegal_o`, and so does supervisor with `tvm_i` set. With virtualisation and `h_en_i` low, any code raises `exc_illegal_o`. With virtualisation and a code of 2 or 3, the request also raises `exc_illegal_o`.
- R4: With `h_en_i` high, virtual-user raises `exc_virtual_o`, and virtual-supervisor with `vtvm_i` set raises `exc_virtual_o`.
- R5: A request that raises either exception leaves every entry unchanged.
- R6: With both zero flags set, every valid entry in the requester's scope is invalidated, global entries included.
- R7: With only the address flag zero, in-scope non-global entries whose ASID equals `req_asid_op_i[ASID_W-1:0]` are invalidated. The upper operand bits are ignored.
- R8: With only the ASID flag zero, in-scope entries whose page equals `req_vaddr_i[38:12]` are invalidated, whatever their ASID and global bit.
- R9: With neither flag zero, only in-scope non-global entries matching both page and ASID are invalidated.
- R10: For requests that use the address, an address whose bits 63 to 38 are not all equal invalidates nothing and raises no exception.
- R11: A virtual-supervisor request reaches only guest entries whose VMID equals `cur_vmid_i`. Any other non-trapping request reaches only non-guest entries.
- R12: A lookup hits the lowest-index valid entry whose page and guest flag match, whose VMID matches when the lookup is a guest lookup, and whose ASID matches unless the entry is global. An entry invalidated by a request misses in every lookup from the `done_o` cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Invalidation request pulse |
| req_rs1_zero_i | input | 1 | Address operand register is the zero register |
| req_rs2_zero_i | input | 1 | ASID operand register is the zero register |
| req_vaddr_i | input | 64 | Virtual address operand |
| req_asid_op_i | input | 64 | ASID operand (low ASID_W bits used) |
| req_priv_i | input | 3 | Requester privilege: [2] virtual, [1:0] base level |
| tvm_i | input | 1 | Trap virtual-memory control for supervisor |
| vtvm_i | input | 1 | Trap virtual-memory control for virtual supervisor |
| h_en_i | input | 1 | Hypervisor extension enabled |
| cur_vmid_i | input | 14 | Current guest VMID |
| fill_valid_i | input | 1 | Write one entry |
| fill_idx_i | input | 3 | Entry index to write |
| fill_vpn_i | input | 27 | Virtual page of the filled entry |
| fill_asid_i | input | 16 | ASID of the filled entry |
| fill_vmid_i | input | 14 | VMID of the filled entry |
| fill_guest_i | input | 1 | Filled entry belongs to a guest |
| fill_global_i | input | 1 | Filled entry is global |
| lkp_vpn_i | input | 27 | Lookup page |
| lkp_asid_i | input | 16 | Lookup ASID |
| lkp_vmid_i | input | 14 | Lookup VMID |
| lkp_guest_i | input | 1 | Lookup is a guest lookup |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_idx_o | output | 3 | Index of the hitting entry |
| done_o | output | 1 | Request completed (one cycle) |
| exc_illegal_o | output | 1 | Request trapped as illegal instruction |
| exc_virtual_o | output | 1 | Request trapped as virtual instruction |

## Verification
The assertions rely on two assumptions about the inputs. First, a fill and a request never fall in the same cycle. Second, fill indices address distinct entries whenever a lookup may match several entries. The stimulus meets both. It refills the whole cache between requests and never raises `fill_valid_i` and `req_valid_i` together. The bench then sweeps every privilege code, every trap-control combination, all four operand forms and both canonical states. It does so over two entry layouts that place global, guest and second-VMID entries at different indices, so that each scope rule both clears and spares some entries.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  localparam logic [1:0] PRV_U   = 2'd0;
  localparam logic [1:0] PRV_RSV = 2'd2;
  localparam logic [1:0] PRV_S   = 2'd1;
  localparam logic [1:0] PRV_M   = 2'd3;

  typedef struct packed {
    logic use_addr;
    logic use_asid;
    logic guest;
  } inval_scope_t;
endpackage

// File: rtl/tlb_inval_decode.sv
module tlb_inval_decode
  import tlb_inval_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int VA_WIDTH  = 39,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 16,
  parameter int VMID_W    = 14,
  localparam int VPN_W    = VA_WIDTH - PAGE_BITS,
  localparam int HI_W     = XLEN - VA_WIDTH + 1
) (
  input  logic              req_valid_i,
  input  logic              rs1_zero_i,
  input  logic              rs2_zero_i,
  input  logic [XLEN-1:0]   vaddr_i,
  input  logic [XLEN-1:0]   asid_op_i,
  input  logic [2:0]        priv_i,
  input  logic              tvm_i,
  input  logic              vtvm_i,
  input  logic              h_en_i,
  output logic              trap_ill_o,
  output logic              trap_virt_o,
  output logic              go_o,
  output inval_scope_t      scope_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o
);
  logic       virt;
  logic [1:0] base;
  logic [HI_W-1:0] hi_bits;
  logic canon;
  logic unused_bits;

  assign virt    = priv_i[2];
  assign base    = priv_i[1:0];
  assign hi_bits = vaddr_i[XLEN-1:VA_WIDTH-1];
  assign canon   = (&hi_bits) | ~(|hi_bits);
  assign unused_bits = ^{vaddr_i[PAGE_BITS-1:0], asid_op_i[XLEN-1:ASID_W]};

  always_comb begin
    trap_ill_o  = 1'b0;
    trap_virt_o = 1'b0;
    if (req_valid_i) begin
      if (!virt) begin
        trap_ill_o = (base == PRV_U) || (base == PRV_RSV) || ((base == PRV_S) && tvm_i);
      end else if (!h_en_i || base[1]) begin
        trap_ill_o = 1'b1;
      end else begin
        trap_virt_o = (base == PRV_U) || vtvm_i;
      end
    end
  end

  assign scope_o.use_addr = !rs1_zero_i;
  assign scope_o.use_asid = !rs2_zero_i;
  assign scope_o.guest    = virt;
  assign vpn_o  = vaddr_i[VA_WIDTH-1:PAGE_BITS];
  assign asid_o = asid_op_i[ASID_W-1:0];

  // non-canonical address: silent no-op
  assign go_o = req_valid_i && !trap_ill_o && !trap_virt_o && (rs1_zero_i || canon);
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_inval_pkg::*;
#(
  parameter int N       = 8,
  parameter int VPN_W   = 27,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 14,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              fill_guest_i,
  input  logic              fill_global_i,
  input  logic              go_i,
  input  inval_scope_t      scope_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [VMID_W-1:0] lkp_vmid_i,
  input  logic              lkp_guest_i,
  output logic [N-1:0]      valid_vec_o,
  output logic [N-1:0]      hit_vec_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic              valid_q, glob_q, guest_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [VMID_W-1:0] vmid_q;
    logic scope_ok, addr_ok, asid_ok, kill, wr;

    assign wr       = fill_valid_i && (fill_idx_i == IDX_W'(i));
    assign scope_ok = scope_i.guest ? (guest_q && (vmid_q == inv_vmid_i)) : !guest_q;
    assign addr_ok  = !scope_i.use_addr || (vpn_q == inv_vpn_i);
    assign asid_ok  = !scope_i.use_asid || (!glob_q && (asid_q == inv_asid_i));
    assign kill     = go_i && valid_q && scope_ok && addr_ok && asid_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        glob_q  <= 1'b0;
        guest_q <= 1'b0;
        vpn_q   <= '0;
        asid_q  <= '0;
        vmid_q  <= '0;
      end else if (wr) begin
        valid_q <= 1'b1;
        glob_q  <= fill_global_i;
        guest_q <= fill_guest_i;
        vpn_q   <= fill_vpn_i;
        asid_q  <= fill_asid_i;
        vmid_q  <= fill_vmid_i;
      end else if (kill) begin
        valid_q <= 1'b0;
      end
    end

    assign valid_vec_o[i] = valid_q;
    assign hit_vec_o[i]   = valid_q && (vpn_q == lkp_vpn_i) && (guest_q == lkp_guest_i)
                            && (!lkp_guest_i || (vmid_q == lkp_vmid_i))
                            && (glob_q || (asid_q == lkp_asid_i));
  end
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hit_vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |hit_vec_i;
endmodule

// File: rtl/tlb_inval_unit.sv
module tlb_inval_unit
  import tlb_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 64,
  parameter int VA_WIDTH    = 39,
  parameter int PAGE_BITS   = 12,
  parameter int ASID_W      = 16,
  parameter int VMID_W      = 14,
  localparam int VPN_W      = VA_WIDTH - PAGE_BITS,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_rs1_zero_i,
  input  logic              req_rs2_zero_i,
  input  logic [XLEN-1:0]   req_vaddr_i,
  input  logic [XLEN-1:0]   req_asid_op_i,
  input  logic [2:0]        req_priv_i,
  input  logic              tvm_i,
  input  logic              vtvm_i,
  input  logic              h_en_i,
  input  logic [VMID_W-1:0] cur_vmid_i,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              fill_guest_i,
  input  logic              fill_global_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [VMID_W-1:0] lkp_vmid_i,
  input  logic              lkp_guest_i,
  output logic              lkp_hit_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  output logic              done_o,
  output logic              exc_illegal_o,
  output logic              exc_virtual_o
);
  logic              trap_ill, trap_virt, go;
  inval_scope_t      scope;
  logic [VPN_W-1:0]  inv_vpn;
  logic [ASID_W-1:0] inv_asid;
  logic [NUM_ENTRIES-1:0] valid_vec, hit_vec;
  logic done_q, ill_q, virt_q;

  tlb_inval_decode #(
    .XLEN(XLEN), .VA_WIDTH(VA_WIDTH), .PAGE_BITS(PAGE_BITS),
    .ASID_W(ASID_W), .VMID_W(VMID_W)
  ) u_decode (
    .req_valid_i (req_valid_i),
    .rs1_zero_i  (req_rs1_zero_i),
    .rs2_zero_i  (req_rs2_zero_i),
    .vaddr_i     (req_vaddr_i),
    .asid_op_i   (req_asid_op_i),
    .priv_i      (req_priv_i),
    .tvm_i       (tvm_i),
    .vtvm_i      (vtvm_i),
    .h_en_i      (h_en_i),
    .trap_ill_o  (trap_ill),
    .trap_virt_o (trap_virt),
    .go_o        (go),
    .scope_o     (scope),
    .vpn_o       (inv_vpn),
    .asid_o      (inv_asid)
  );

  tlb_entry_array #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)
  ) u_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fill_valid_i  (fill_valid_i),
    .fill_idx_i    (fill_idx_i),
    .fill_vpn_i    (fill_vpn_i),
    .fill_asid_i   (fill_asid_i),
    .fill_vmid_i   (fill_vmid_i),
    .fill_guest_i  (fill_guest_i),
    .fill_global_i (fill_global_i),
    .go_i          (go),
    .scope_i       (scope),
    .inv_vpn_i     (inv_vpn),
    .inv_asid_i    (inv_asid),
    .inv_vmid_i    (cur_vmid_i),
    .lkp_vpn_i     (lkp_vpn_i),
    .lkp_asid_i    (lkp_asid_i),
    .lkp_vmid_i    (lkp_vmid_i),
    .lkp_guest_i   (lkp_guest_i),
    .valid_vec_o   (valid_vec),
    .hit_vec_o     (hit_vec)
  );

  tlb_hit_select #(.N(NUM_ENTRIES)) u_sel (
    .hit_vec_i (hit_vec),
    .hit_o     (lkp_hit_o),
    .idx_o     (lkp_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      virt_q <= 1'b0;
    end else begin
      done_q <= req_valid_i;
      ill_q  <= trap_ill;
      virt_q <= trap_virt;
    end
  end

  assign done_o        = done_q;
  assign exc_illegal_o = ill_q;
  assign exc_virtual_o = virt_q;
endmodule

module tlb_inval_unit_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_priv_i,
  input logic             fill_valid_i,
  input logic             done_o,
  input logic             exc_illegal_o,
  input logic             exc_virtual_o,
  input logic             lkp_hit_o,
  input logic [IDX_W-1:0] lkp_idx_o,
  input logic [N-1:0]     valid_vec
);
  // R2
  done_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  // R2
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  // R2
  exc_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_illegal_o || exc_virtual_o) |-> done_o);
  // R2
  exc_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_illegal_o && exc_virtual_o));
  // R3
  user_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_priv_i == 3'd0) |=> exc_illegal_o);
  // R5
  trap_keeps_entries_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_illegal_o || exc_virtual_o) && !$past(fill_valid_i)) |-> valid_vec == $past(valid_vec));
  // R6
  inval_only_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |=> (valid_vec & ~$past(valid_vec)) == '0);
  // R12
  hit_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> valid_vec[lkp_idx_o]);
endmodule

bind tlb_inval_unit tlb_inval_unit_chk #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_priv_i    (req_priv_i),
  .fill_valid_i  (fill_valid_i),
  .done_o        (done_o),
  .exc_illegal_o (exc_illegal_o),
  .exc_virtual_o (exc_virtual_o),
  .lkp_hit_o     (lkp_hit_o),
  .lkp_idx_o     (lkp_idx_o),
  .valid_vec     (valid_vec)
);

// File: tb/tlb_inval_unit_bench.sv
module tlb_inval_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, XLEN = 64, VPN_W = 27, ASID_W = 16, VMID_W = 14, IDX_W = 3;
  localparam logic [VPN_W-1:0]  VPN_A  = 27'h4012345;
  localparam logic [ASID_W-1:0] ASID_X = 16'h00A1;
  localparam logic [ASID_W-1:0] ASID_Y = 16'h0035;
  localparam logic [VMID_W-1:0] VM_CUR = 14'h0011;
  localparam logic [VMID_W-1:0] VM_OTH = 14'h0022;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0, rs1z = 0, rs2z = 0, tvm = 0, vtvm = 0, h_en = 0;
  logic [XLEN-1:0] vaddr = '0, asid_op = '0;
  logic [2:0] priv = '0;
  logic [VMID_W-1:0] cur_vmid = VM_CUR;
  logic fill_valid = 0, fill_guest = 0, fill_global = 0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [VPN_W-1:0] fill_vpn = '0, lkp_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0, lkp_asid = '0;
  logic [VMID_W-1:0] fill_vmid = '0, lkp_vmid = '0;
  logic lkp_guest = 0;
  logic lkp_hit, done, exc_ill, exc_virt;
  logic [IDX_W-1:0] lkp_idx;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic              m_valid [N];
  logic [VPN_W-1:0]  m_vpn   [N];
  logic [ASID_W-1:0] m_asid  [N];
  logic [VMID_W-1:0] m_vmid  [N];
  logic              m_guest [N];
  logic              m_glob  [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_inval_unit u_tlb_inval_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_rs1_zero_i(rs1z),
    .req_rs2_zero_i(rs2z), .req_vaddr_i(vaddr), .req_asid_op_i(asid_op), .req_priv_i(priv),
    .tvm_i(tvm), .vtvm_i(vtvm), .h_en_i(h_en), .cur_vmid_i(cur_vmid),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn),
    .fill_asid_i(fill_asid), .fill_vmid_i(fill_vmid), .fill_guest_i(fill_guest),
    .fill_global_i(fill_global), .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid),
    .lkp_vmid_i(lkp_vmid), .lkp_guest_i(lkp_guest), .lkp_hit_o(lkp_hit),
    .lkp_idx_o(lkp_idx), .done_o(done), .exc_illegal_o(exc_ill), .exc_virtual_o(exc_virt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_all(input int p);
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b1;
      m_vpn[i]   = VPN_A + VPN_W'(i & 1);
      m_asid[i]  = ((((i >> 1) ^ p) & 1) != 0) ? ASID_X : ASID_Y;
      m_guest[i] = ((i >> 2) & 1) != 0;
      m_vmid[i]  = (i == 7 - p) ? VM_OTH : VM_CUR;
      m_glob[i]  = (i == 2 + p) || (i == 5 + p);
      @(negedge clk);
      fill_valid = 1; fill_idx = IDX_W'(i); fill_vpn = m_vpn[i]; fill_asid = m_asid[i];
      fill_vmid = m_vmid[i]; fill_guest = m_guest[i]; fill_global = m_glob[i];
    end
    @(negedge clk);
    fill_valid = 0;
  endtask

  // lookup of each entry's own key; expected = lowest matching model entry
  task automatic check_lookups(input string tag);
    for (int i = 0; i < N; i++) begin
      logic eh;
      logic [IDX_W-1:0] ei;
      lkp_vpn = m_vpn[i]; lkp_asid = m_asid[i]; lkp_vmid = m_vmid[i]; lkp_guest = m_guest[i];
      eh = 0; ei = '0;
      for (int j = N - 1; j >= 0; j--) begin
        if (m_valid[j] && m_vpn[j] == m_vpn[i] && m_guest[j] == m_guest[i]
            && (!m_guest[i] || m_vmid[j] == m_vmid[i]) && (m_glob[j] || m_asid[j] == m_asid[i])) begin
          eh = 1; ei = IDX_W'(j);
        end
      end
      #1;
      check({tag, " R12 hit"}, 32'(lkp_hit), 32'(eh));
      if (eh) check({tag, " R12 idx"}, 32'(lkp_idx), 32'(ei));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_vpn[i] = VPN_A + VPN_W'(i & 1); m_asid[i] = ASID_X;
      m_vmid[i] = VM_CUR; m_guest[i] = (i >> 2) != 0; m_glob[i] = 0;
    end
    check("R1 done", 32'(done), 0);
    check("R1 exc", 32'({exc_ill, exc_virt}), 0);
    check_lookups("R1");

    for (int p = 0; p < 2; p++)
      for (int pr = 0; pr < 8; pr++)
        for (int ctl = 0; ctl < 8; ctl++)
          for (int kind = 0; kind < 4; kind++)
            for (int cn = 0; cn < 2; cn++) begin
              logic virt, ill, vi, ua, us, canon, go;
              logic [1:0] b;
              logic [VPN_W-1:0] tvpn;
              string tag;
              fill_all(p);
              virt = pr[2]; b = pr[1:0];
              ua = kind[1]; us = kind[0]; canon = (cn == 0);
              tvpn = VPN_A + VPN_W'(p);
              ill = virt ? (!ctl[2] || b[1]) : (b == 2'd0 || b == 2'd2 || (b == 2'd1 && ctl[0]));
              vi  = !ill && virt && (b == 2'd0 || ctl[1]);
              go  = !ill && !vi && (!ua || canon);
              @(negedge clk);
              req_valid = 1; priv = 3'(pr); tvm = ctl[0]; vtvm = ctl[1]; h_en = ctl[2];
              rs1z = !ua; rs2z = !us;
              vaddr = {{25{1'b1}}, tvpn, 12'h5A5};
              if (!canon) vaddr[60] = 1'b0;
              asid_op = {48'hDEAD_BEEF_0000, ASID_X};
              @(negedge clk);
              req_valid = 0;
              check("R2 done", 32'(done), 1);
              check("R3 illegal", 32'(exc_ill), 32'(ill));
              check("R4 virtual", 32'(exc_virt), 32'(vi));
              for (int j = 0; j < N; j++) begin
                logic sc, ak, sk;
                sc = virt ? (m_guest[j] && m_vmid[j] == VM_CUR) : !m_guest[j];
                ak = !ua || m_vpn[j] == tvpn;
                sk = !us || (!m_glob[j] && m_asid[j] == ASID_X);
                if (go && sc && ak && sk) m_valid[j] = 0;
              end
              if (ill || vi) tag = "R5";
              else if (ua && !canon) tag = "R10";
              else if (!ua && !us) tag = "R6 R11";
              else if (!ua) tag = "R7 R11";
              else if (!us) tag = "R8 R11";
              else tag = "R9 R11";
              check_lookups(tag);
              @(negedge clk);
              check("R2 pulse", 32'(done), 0);
            end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule